// File: doc/BRIEF.md
# PHY Event Interrupt Register

This block is one 16-bit word in an Ethernet PHY's management register space. It watches the live link, speed and duplex state, an auto-negotiation completion pulse, and the values of two 8-bit error counters: false carrier and receive error. It turns each of these six kinds of activity into a sticky status flag. The same word also holds six enable flags, one for each status flag. The block drives an interrupt request whenever an enabled flag is set and the global interrupt gate is open.

Management logic reads and writes the word through a simple register port. A read that hits the word returns the current value and clears all six status flags. A write that hits the word changes only the enable flags. The counters themselves live outside this block; only their values are observed here.

Top module: `phy_evt_irq_reg`

## Requirements
- R1: While reset is asserted and right after it, every status and enable flag is zero and a read of the word returns 0x0000.
- R2: The word sits at address 0x12. A read there returns the status flags in bits 13..8 and the enable flags in bits 5..0, with bits 15:14 and 7:6 always zero. The status order is link change (13), speed change (12), duplex change (11), auto-negotiation done (10), false-carrier half-full (9) and receive-error half-full (8). The enable order is the same: link (5), speed (4), duplex (3), auto-negotiation (2), false-carrier (1) and receive-error (0). A read at any other address returns zero.
- R3: Any change of the link, speed or duplex input between two clock edges sets its status flag at the second edge, for a change in either direction. No change is reported on the first clock edge after reset.
- R4: An auto-negotiation done input that is high at a clock edge sets bit 10.
- R5: A counter moving from below 128 to 128 or more sets its half-full flag once. While the counter stays at 128 or above, no further event occurs, so a cleared flag stays clear until the counter drops below 128 and crosses again. No crossing is reported on the first edge after reset.
- R6: Status flags stay set until the word is read, and they latch events even when their enable flag is clear.
- R7: A read of the word clears all status flags at that clock edge and returns the values they held before the clear. An event in the same cycle as the read stays set after it.
- R8: A write to the word loads bits 5..0 into the enable flags and ignores all other bits. A write to any other address changes nothing.
- R9: The interrupt output is high exactly when the global enable input is high and at least one status flag has its enable flag set.
- R10: Reads at other addresses leave the status flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Live link state |
| speed_sel | input | 1 | Live speed state |
| full_duplex | input | 1 | Live duplex state |
| an_done | input | 1 | Auto-negotiation done pulse |
| fc_count | input | 8 | False-carrier counter value |
| rxerr_count | input | 8 | Receive-error counter value |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| glb_irq_en | input | 1 | Global interrupt enable |
| reg_rdata | output | 16 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets a counter that sits above 128 after its flag has been read. A level-based detector would set the flag again at once, and this shows up as a status bit that will not stay clear.

It also puts an event in the same cycle as a clearing read. A design that lets the clear win would lose that event, and one that returns the new value would set the flag in the read data too early.

Inputs are held non-zero across reset release, which catches spurious change events on the first edge after reset. Writes of all ones and accesses at other addresses would expose status or reserved bits that could be written, and a clear that ignores the address.

// File: rtl/phy_evt_irq_reg.sv
module phy_evt_irq_reg #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] REG_ADDR = 5'h12,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              speed_sel,
  input  logic              full_duplex,
  input  logic              an_done,
  input  logic [CNT_W-1:0]  fc_count,
  input  logic [CNT_W-1:0]  rxerr_count,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  input  logic              glb_irq_en,
  output logic [15:0]       reg_rdata,
  output logic              irq
);
  localparam int NEV = 6;

  logic [NEV-1:0] stat_q, en_q, ev;
  logic [4:0]     prev_q;
  logic           primed_q;
  logic           hit, rd_hit, wr_hit;

  assign hit    = (reg_addr == REG_ADDR);
  assign rd_hit = hit && reg_rd;
  assign wr_hit = hit && reg_wr;

  // live snapshot: link, speed, duplex, fc msb, rxerr msb
  logic [4:0] live;
  assign live = {link_up, speed_sel, full_duplex, fc_count[CNT_W-1], rxerr_count[CNT_W-1]};

  assign ev[5] = primed_q && (live[4] != prev_q[4]);
  assign ev[4] = primed_q && (live[3] != prev_q[3]);
  assign ev[3] = primed_q && (live[2] != prev_q[2]);
  assign ev[2] = an_done;
  assign ev[1] = primed_q && live[1] && !prev_q[1];
  assign ev[0] = primed_q && live[0] && !prev_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= '0;
      en_q     <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= live;
      primed_q <= 1'b1;
      stat_q   <= (rd_hit ? '0 : stat_q) | ev;
      if (wr_hit) en_q <= reg_wdata[NEV-1:0];
    end
  end

  assign reg_rdata = hit ? {2'b00, stat_q, 2'b00, en_q} : 16'h0000;
  assign irq       = glb_irq_en && |(stat_q & en_q);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && ev == '0) |=> (stat_q == '0));
  a_r3_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));
  a_r8_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(en_q));
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_irq_en);
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15:14] == 2'b00) && (reg_rdata[7:6] == 2'b00));
endmodule

// File: tb/phy_evt_irq_reg_bench.sv
`timescale 1ns/100ps
module phy_evt_irq_reg_bench;
  logic clk = 0, rst_n = 0;
  logic link_up = 0, speed_sel = 0, full_duplex = 0, an_done = 0;
  logic [7:0] fc_count = 0, rxerr_count = 0;
  logic [4:0] reg_addr = 0;
  logic reg_rd = 0, reg_wr = 0, glb_irq_en = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic irq;

  phy_evt_irq_reg u_phy_evt_irq_reg (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0;
  logic [5:0] m_stat = 0, m_en = 0;
  logic [4:0] m_prev = 0;
  logic m_primed = 0;

  function automatic logic [15:0] exp_word();
    return (reg_addr == 5'h12) ? {2'b00, m_stat, 2'b00, m_en} : 16'h0;
  endfunction

  function automatic logic [5:0] exp_ev();
    logic [4:0] lv;
    lv = {link_up, speed_sel, full_duplex, fc_count[7], rxerr_count[7]};
    return {m_primed && lv[4] != m_prev[4], m_primed && lv[3] != m_prev[3],
            m_primed && lv[2] != m_prev[2], an_done,
            m_primed && lv[1] && !m_prev[1], m_primed && lv[0] && !m_prev[0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at negedge with inputs driven; checks outputs then advances one cycle
  task automatic tick(input string req);
    #1;
    check({req, " rdata"}, reg_rdata, exp_word());
    check("R9 irq", {15'b0, irq}, {15'b0, glb_irq_en && |(m_stat & m_en)});
    if (rst_n) begin
      logic [5:0] e;
      e = exp_ev();
      m_stat = ((reg_rd && reg_addr == 5'h12) ? 6'b0 : m_stat) | e;
      if (reg_wr && reg_addr == 5'h12) m_en = reg_wdata[5:0];
      m_prev = {link_up, speed_sel, full_duplex, fc_count[7], rxerr_count[7]};
      m_primed = 1;
    end else begin
      m_stat = 0; m_en = 0; m_prev = 0; m_primed = 0;
    end
    @(posedge clk);
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; an_done = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string req);
    reg_addr = a; reg_rd = 1; tick(req);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input string req);
    reg_addr = a; reg_wr = 1; reg_wdata = d; tick(req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset state, with inputs non-zero across release
    link_up = 1; speed_sel = 1; fc_count = 8'd200; reg_addr = 5'h12;
    tick("R1"); tick("R1");
    rst_n = 1;
    tick("R1 first edge");
    rd(5'h12, "R3 R5 no event after reset");
    check("R1 clean after reset", reg_rdata, 16'h0000);
    // R8: write all ones, only enables take
    wr(5'h12, 16'hFFFF, "R8");
    rd(5'h12, "R8 readback");
    wr(5'h03, 16'h0000, "R8 other address");
    rd(5'h12, "R8 unchanged");
    // R3 link drop, R6 latched
    link_up = 0; tick("R3");
    reg_addr = 5'h12; tick("R3 link set");
    check("R3 link bit13", reg_rdata, 16'h203F);
    rd(5'h07, "R10 other read");
    reg_addr = 5'h12; tick("R10 still set");
    // R7: read with same-cycle event
    full_duplex = 1; rd(5'h12, "R7 old value");
    reg_addr = 5'h12; tick("R7 event kept");
    check("R7 duplex survives", reg_rdata, 16'h083F);
    glb_irq_en = 1; tick("R9");
    // R4
    an_done = 1; rd(5'h12, "R4");
    reg_addr = 5'h12; tick("R4 set");
    check("R4 bit10", reg_rdata, 16'h043F);
    rd(5'h12, "R7 clear");
    // R5: crossing once
    rxerr_count = 8'd127; tick("R5");
    rxerr_count = 8'd128; tick("R5 cross");
    rd(5'h12, "R5 set");
    rxerr_count = 8'd255; tick("R5 hold");
    reg_addr = 5'h12; tick("R5 no refire");
    check("R5 stays clear", reg_rdata, 16'h003F);
    fc_count = 8'd10; tick("R5 drop");
    fc_count = 8'd130; tick("R5 fc cross");
    // R6 with enables off
    wr(5'h12, 16'h0000, "R6");
    speed_sel = 0; tick("R6 latch disabled");
    reg_addr = 5'h12; tick("R6");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6) link_up = ~link_up;
      else if (r < 12) speed_sel = ~speed_sel;
      else if (r < 18) full_duplex = ~full_duplex;
      an_done = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 9) == 0) fc_count = 8'($urandom);
      if ($urandom_range(0, 9) == 0) rxerr_count = 8'($urandom);
      reg_addr = ($urandom_range(0, 3) != 0) ? 5'h12 : 5'($urandom);
      reg_rd = ($urandom_range(0, 3) == 0);
      reg_wr = ($urandom_range(0, 7) == 0);
      reg_wdata = 16'($urandom);
      glb_irq_en = ($urandom_range(0, 4) != 0);
      tick("R2 R3 R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule